// File: doc/BRIEF.md
# Machine-Cycle Timer/Counter with Overflow Toggle

This block is a 16-bit up-counter built as a high byte and a low byte. It advances on a machine-cycle enable. As a timer it counts every machine cycle. As an event counter it counts falling edges of an external input, and it samples that input once per machine cycle. In the 13-bit mode, the low five bits of the low byte form a divide-by-32 prescaler that feeds the 8-bit high byte. In the 16-bit mode, both bytes form one counter.

When the count wraps to zero it sets a sticky overflow flag. If the toggle option is on, the wrap also inverts a toggle output pin. Software-style loads of either byte go through a shared data port and take priority over counting. A run bit starts and stops the count.

Top module: `mc_timer`

## Requirements
- R1: With `run`=1 and `fn_event`=0 (timer), the count advances by one at each clock edge where `mc_en`=1. It does not change at edges where `mc_en`=0.
- R2: With `fn_event`=1 (event counter), `ext_cnt_in` is sampled only at edges where `mc_en`=1. The count advances by one at a sampling edge whose sample is 0 while the previous sample was 1. The stored sample is 0 after reset.
- R3: With `mode_full`=0 (13-bit), bits [4:0] of the low byte form a prescaler. When the prescaler wraps from 31 to 0, the high byte advances. Counting never changes bits [7:5] of the low byte.
- R4: With `mode_full`=1 (16-bit), {`cnt_hi`,`cnt_lo`} advances as one 16-bit value. The low byte carries from FFh into the high byte.
- R5: An overflow is a wrap from high byte FFh with prescaler 1Fh in 13-bit mode, or from FFFFh in 16-bit mode. It sets `ovf_flag` at the same edge as the wrap.
- R6: `ovf_flag` stays set until an edge with `ovf_clr`=1. If an overflow and `ovf_clr` occur in the same cycle, the flag ends set.
- R7: With `tgl_en`=1, `tgl_out` inverts at every overflow. With `tgl_en`=0, an overflow leaves `tgl_out` unchanged.
- R8: `wr_lo`/`wr_hi` load `wr_data` into the low/high byte at the next edge. A write to either byte cancels the increment for that cycle, and the unwritten byte holds.
- R9: With `run`=0, the count and `tgl_out` hold their values, whatever `mc_en` and `ext_cnt_in` do.
- R10: Reset (`rst_n`=0, asynchronous) clears both count bytes, `ovf_flag` and `tgl_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_en | input | 1 | Machine-cycle enable, one clock wide |
| ext_cnt_in | input | 1 | External event input, already synchronous to clk |
| run | input | 1 | Counting allowed when 1 |
| mode_full | input | 1 | 0: 13-bit prescaled mode, 1: 16-bit mode |
| fn_event | input | 1 | 0: timer, 1: event counter |
| tgl_en | input | 1 | Enable output toggle on overflow |
| wr_lo | input | 1 | Load low byte from wr_data |
| wr_hi | input | 1 | Load high byte from wr_data |
| wr_data | input | 8 | Load data |
| ovf_clr | input | 1 | Clear overflow flag |
| cnt_lo | output | 8 | Low count byte |
| cnt_hi | output | 8 | High count byte |
| ovf_flag | output | 1 | Sticky overflow flag |
| tgl_out | output | 1 | Toggle output pin |

## Verification
Every result is due at the first clock edge after the stimulus: count, flag and toggle output all register there. An event-counter edge is counted at the same edge that takes the low sample. A hold or an ignored input must still show an unchanged value one edge later. The bench drives inputs 1 ns after a rising edge and advances exactly one edge per step. It then samples 1 ns after that edge, so each comparison sees the value registered by the intended edge and no later one.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int DEF_BYTE_W = 8;
   localparam int DEF_PRE_W  = 5;

   typedef enum logic {
      FN_TIMER = 1'b0,
      FN_EVENT = 1'b1
   } tmr_fn_e;

   typedef enum logic {
      MODE_PRESCALED = 1'b0,
      MODE_FULL      = 1'b1
   } tmr_mode_e;
endpackage

// File: rtl/tmr_edge_smp.sv
module tmr_edge_smp (
   input  logic clk,
   input  logic rst_n,
   input  logic smp_en_i,
   input  logic pin_i,
   output logic fall_o
);
   logic smp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        smp_q <= 1'b0;
      else if (smp_en_i) smp_q <= pin_i;
   end

   assign fall_o = smp_en_i && smp_q && !pin_i;

   // R2: the stored sample only moves on a sampling cycle
   p_sample_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_en_i |=> $stable(smp_q));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int BYTE_W = tmr_pkg::DEF_BYTE_W,
   parameter int PRE_W  = tmr_pkg::DEF_PRE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc_i,
   input  logic              mode_full_i,
   input  logic              wr_lo_i,
   input  logic              wr_hi_i,
   input  logic [BYTE_W-1:0] wr_data_i,
   output logic [BYTE_W-1:0] lo_o,
   output logic [BYTE_W-1:0] hi_o,
   output logic              wrap_o
);
   localparam int FULL_W = 2 * BYTE_W;
   localparam int UP_W   = BYTE_W - PRE_W;

   logic [BYTE_W-1:0] lo_q, hi_q, lo_nxt, hi_nxt;
   logic [PRE_W-1:0]  pre, pre_nxt;
   logic              carry, step;

   if (PRE_W < 1 || PRE_W >= BYTE_W) begin : g_bad_pre
      $error("tmr_count_core: PRE_W must be in 1..BYTE_W-1");
   end

   assign pre     = lo_q[PRE_W-1:0];
   assign pre_nxt = pre + 1'b1;
   assign step    = inc_i && !wr_lo_i && !wr_hi_i;

   always_comb begin
      if (mode_full_i) begin
         lo_nxt = lo_q + 1'b1;
         carry  = &lo_q;
      end else begin
         lo_nxt = {lo_q[BYTE_W-1:PRE_W], pre_nxt};
         carry  = &pre;
      end
      hi_nxt = carry ? hi_q + 1'b1 : hi_q;
   end

   assign wrap_o = step && carry && (&hi_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (wr_lo_i || wr_hi_i) begin
         if (wr_lo_i) lo_q <= wr_data_i;
         if (wr_hi_i) hi_q <= wr_data_i;
      end else if (step) begin
         lo_q <= lo_nxt;
         hi_q <= hi_nxt;
      end
   end

   assign lo_o = lo_q;
   assign hi_o = hi_q;

   // R9 / R1: no increment request and no write keeps the count still
   p_hold_noinc_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !wr_lo_i && !wr_hi_i) |=> $stable({hi_q, lo_q}));
   // R8: writes land on the next edge
   p_load_lo_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo_i |=> (lo_q == $past(wr_data_i)));
   p_load_hi_r8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi_i |=> (hi_q == $past(wr_data_i)));
   // R3: bits above the prescaler are untouched by counting
   p_upper_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_full_i && !wr_lo_i) |=> $stable(lo_q[BYTE_W-1:BYTE_W-UP_W]));
   // R4: 16-bit mode advances the joined value by one
   p_full_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !wr_lo_i && !wr_hi_i && mode_full_i) |=>
      ({hi_q, lo_q} == $past({hi_q, lo_q}) + FULL_W'(1)));
endmodule

// File: rtl/tmr_toggle_out.sv
module tmr_toggle_out (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_i,
   input  logic tgl_en_i,
   output logic tgl_o
);
   logic tgl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 tgl_q <= 1'b0;
      else if (ovf_i && tgl_en_i) tgl_q <= !tgl_q;
   end

   assign tgl_o = tgl_q;

   // R7: pin moves only on an enabled overflow, and then it always moves
   p_tgl_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_i && tgl_en_i) |=> $stable(tgl_q));
   p_tgl_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_i && tgl_en_i) |=> (tgl_q != $past(tgl_q)));
endmodule

// File: rtl/mc_timer.sv
module mc_timer #(
   parameter int BYTE_W = tmr_pkg::DEF_BYTE_W,
   parameter int PRE_W  = tmr_pkg::DEF_PRE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mc_en,
   input  logic              ext_cnt_in,
   input  logic              run,
   input  logic              mode_full,
   input  logic              fn_event,
   input  logic              tgl_en,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [BYTE_W-1:0] wr_data,
   input  logic              ovf_clr,
   output logic [BYTE_W-1:0] cnt_lo,
   output logic [BYTE_W-1:0] cnt_hi,
   output logic              ovf_flag,
   output logic              tgl_out
);
   import tmr_pkg::*;

   tmr_fn_e   fn_sel;
   tmr_mode_e mode_sel;
   logic      fall, inc, wrap, flag_q;

   assign fn_sel   = tmr_fn_e'(fn_event);
   assign mode_sel = tmr_mode_e'(mode_full);

   tmr_edge_smp u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .smp_en_i (mc_en),
      .pin_i    (ext_cnt_in),
      .fall_o   (fall)
   );

   assign inc = run && mc_en && ((fn_sel == FN_EVENT) ? fall : 1'b1);

   tmr_count_core #(.BYTE_W(BYTE_W), .PRE_W(PRE_W)) u_core (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_i       (inc),
      .mode_full_i (mode_sel == MODE_FULL),
      .wr_lo_i     (wr_lo),
      .wr_hi_i     (wr_hi),
      .wr_data_i   (wr_data),
      .lo_o        (cnt_lo),
      .hi_o        (cnt_hi),
      .wrap_o      (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       flag_q <= 1'b0;
      else if (wrap)    flag_q <= 1'b1;
      else if (ovf_clr) flag_q <= 1'b0;
   end
   assign ovf_flag = flag_q;

   tmr_toggle_out u_tgl (
      .clk      (clk),
      .rst_n    (rst_n),
      .ovf_i    (wrap),
      .tgl_en_i (tgl_en),
      .tgl_o    (tgl_out)
   );

   // R5: a wrap always leaves the flag set
   p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> ovf_flag);
   // R6: only a clear request can drop the flag
   p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag);
   // R9: stopped timer keeps its toggle pin
   p_run_hold_tgl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(tgl_out));
endmodule

// File: tb/mc_timer_bench.sv
module mc_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_en = 0, ext_cnt_in = 0, run = 0, mode_full = 0, fn_event = 0;
   logic       tgl_en = 0, wr_lo = 0, wr_hi = 0, ovf_clr = 0;
   logic [7:0] wr_data = '0;
   logic [7:0] cnt_lo, cnt_hi;
   logic       ovf_flag, tgl_out;

   int  checks = 0;
   int  failures = 0;
   bit  done = 1'b0;

   always #2 clk = ~clk;

   mc_timer u_mc_timer (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .ext_cnt_in(ext_cnt_in),
      .run(run), .mode_full(mode_full), .fn_event(fn_event), .tgl_en(tgl_en),
      .wr_lo(wr_lo), .wr_hi(wr_hi), .wr_data(wr_data), .ovf_clr(ovf_clr),
      .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .ovf_flag(ovf_flag), .tgl_out(tgl_out)
   );

   // Row layout: [39] run [38] mc_en [37] fn_event [36] ext [35] mode_full
   // [34] wr_lo [33] wr_hi [32] ovf_clr [31:24] data [23:16] exp lo
   // [15:8] exp hi [7] exp flag [6] exp toggle [5:0] requirement number
   localparam int NV = 20;
   localparam logic [39:0] VEC [NV] = '{
      {8'b00000100, 8'hFE, 8'hFE, 8'h00, 8'b00_001000}, // R8 load lo
      {8'b00000010, 8'hFF, 8'hFE, 8'hFF, 8'b00_001000}, // R8 load hi
      {8'b11001000, 8'h00, 8'hFF, 8'hFF, 8'b00_000001}, // R1 timer step
      {8'b11001000, 8'h00, 8'h00, 8'h00, 8'b11_000101}, // R5 R7 16-bit wrap
      {8'b10001000, 8'h00, 8'h00, 8'h00, 8'b11_000001}, // R1 no mc_en
      {8'b00001001, 8'h00, 8'h00, 8'h00, 8'b01_000110}, // R6 clear
      {8'b00000100, 8'hE0, 8'hE0, 8'h00, 8'b01_001000}, // R8
      {8'b00000010, 8'hFF, 8'hE0, 8'hFF, 8'b01_001000}, // R8
      {8'b00000100, 8'hFE, 8'hFE, 8'hFF, 8'b01_001000}, // R8
      {8'b11000000, 8'h00, 8'hFF, 8'hFF, 8'b01_000011}, // R3 prescaler step
      {8'b11000000, 8'h00, 8'hE0, 8'h00, 8'b10_000011}, // R3 R5 R7 13-bit wrap
      {8'b11110000, 8'h00, 8'hE0, 8'h00, 8'b10_000010}, // R2 sample high
      {8'b11100000, 8'h00, 8'hE1, 8'h00, 8'b10_000010}, // R2 falling edge
      {8'b11100000, 8'h00, 8'hE1, 8'h00, 8'b10_000010}, // R2 steady low
      {8'b10110000, 8'h00, 8'hE1, 8'h00, 8'b10_000010}, // R2 not sampled
      {8'b11100000, 8'h00, 8'hE1, 8'h00, 8'b10_000010}, // R2 prev sample low
      {8'b11110000, 8'h00, 8'hE1, 8'h00, 8'b10_000010}, // R2 rise
      {8'b01100000, 8'h00, 8'hE1, 8'h00, 8'b10_001001}, // R9 run off
      {8'b11110000, 8'h00, 8'hE1, 8'h00, 8'b10_000010}, // R2 rise again
      {8'b11100100, 8'h05, 8'h05, 8'h00, 8'b10_001000}  // R8 write beats edge
   };

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      run = 0; mc_en = 0; wr_lo = 0; wr_hi = 0; ovf_clr = 0;
   endtask

   task automatic load16(input logic [7:0] hi, input logic [7:0] lo);
      idle();
      wr_lo = 1; wr_data = lo; tick();
      wr_lo = 0; wr_hi = 1; wr_data = hi; tick();
      wr_hi = 0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      // R10 reset state
      chk("R10", "lo", cnt_lo, 0);
      chk("R10", "hi", cnt_hi, 0);
      chk("R10", "flag", ovf_flag, 0);
      chk("R10", "tgl", tgl_out, 0);
      rst_n = 1'b1;
      tick();
      chk("R10", "lo after release", cnt_lo, 0);

      tgl_en = 1;
      for (int i = 0; i < NV; i++) begin
         logic [39:0] v;
         string tag;
         v = VEC[i];
         run = v[39]; mc_en = v[38]; fn_event = v[37]; ext_cnt_in = v[36];
         mode_full = v[35]; wr_lo = v[34]; wr_hi = v[33]; ovf_clr = v[32];
         wr_data = v[31:24];
         tick();
         tag = $sformatf("R%0d", v[5:0]);
         chk(tag, $sformatf("row%0d lo", i), cnt_lo, v[23:16]);
         chk(tag, $sformatf("row%0d hi", i), cnt_hi, v[15:8]);
         chk(tag, $sformatf("row%0d flag", i), ovf_flag, v[7]);
         chk(tag, $sformatf("row%0d tgl", i), tgl_out, v[6]);
      end
      idle(); fn_event = 0; ext_cnt_in = 0;

      // R4 16-bit carry from low into high
      mode_full = 1;
      load16(8'h12, 8'hFF);
      run = 1; mc_en = 1; tick(); idle();
      chk("R4", "lo", cnt_lo, 8'h00);
      chk("R4", "hi", cnt_hi, 8'h13);
      chk("R6", "flag still set", ovf_flag, 1);
      ovf_clr = 1; tick(); ovf_clr = 0;
      chk("R6", "flag cleared", ovf_flag, 0);

      // R3 13-bit carry, upper bits of low byte kept
      mode_full = 0;
      load16(8'h07, 8'h5F);
      run = 1; mc_en = 1; tick(); idle();
      chk("R3", "lo", cnt_lo, 8'h40);
      chk("R3", "hi", cnt_hi, 8'h08);
      chk("R5", "no overflow", ovf_flag, 0);

      // R7 overflow with toggle disabled
      mode_full = 1; tgl_en = 0;
      load16(8'hFF, 8'hFF);
      run = 1; mc_en = 1; tick(); idle();
      chk("R5", "flag 16-bit wrap", ovf_flag, 1);
      chk("R7", "tgl held when disabled", tgl_out, 0);
      chk("R4", "wrap lo", cnt_lo, 0);

      // R6 clear and overflow in the same cycle
      ovf_clr = 1; tick(); ovf_clr = 0;
      chk("R6", "flag cleared", ovf_flag, 0);
      tgl_en = 1;
      load16(8'hFF, 8'hFF);
      run = 1; mc_en = 1; ovf_clr = 1; tick(); idle();
      chk("R6", "set wins over clear", ovf_flag, 1);
      chk("R7", "tgl flips", tgl_out, 1);

      // R9 run low with machine cycles does nothing
      load16(8'h00, 8'h10);
      mc_en = 1; run = 0; repeat (4) tick(); idle();
      chk("R9", "lo held", cnt_lo, 8'h10);
      chk("R9", "tgl held", tgl_out, 1);

      // R10 reset in the middle of counting
      run = 1; mc_en = 1; repeat (3) tick();
      chk("R1", "three steps", cnt_lo, 8'h13);
      rst_n = 0; #1;
      chk("R10", "lo async", cnt_lo, 0);
      chk("R10", "flag async", ovf_flag, 0);
      chk("R10", "tgl async", tgl_out, 0);
      idle(); tick(); rst_n = 1; tick();
      chk("R10", "hi after reset", cnt_hi, 0);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule